// File: doc/BRIEF.md
# Synchronous SRAM DLL Reset and Lock Sequencer

This controller-side block brings the delay-locked loop inside an external synchronous SRAM into a known, locked condition before any traffic is issued. It runs once after power-up and again on every change of the memory clock frequency, with no power cycle in between. A single request pulse starts it. That same pulse also serves as the frequency-change notice.

Two reset methods are available, chosen per request. The first parks the memory clock pair at a static level: the clock enable is withdrawn, but only on a low phase of the memory clock. The second drives the active-low DLL-disable pin low for a programmed time and then raises it, because the rising edge is what resets the DLL. After either method, the clock runs steadily for a programmed lock period, and then the ready flag rises. Every duration is a count of controller clock cycles, captured when the request arrives.

The first request after reset adds a power-hold phase. During that phase the clock enable and the DLL-disable pin are both held low at defined levels. Clock generation and the memory data path sit outside this block, which supplies only the clock-enable control that the clock generator applies.

Top module: `dll_lock_seq`

## Requirements
- R1: While reset is asserted, and while idle afterwards with no request, `mem_clk_en`, `dll_off_n` and `ready` are all 0.
- R2: The first request after reset enters a power hold that keeps `mem_clk_en` and `dll_off_n` at 0 for exactly `pwr_cycles` cycles, counted from the clock edge that samples the request.
- R3: With `method_sel` = 0 (clock park), the reset action drives `dll_off_n` to 1 and withdraws `mem_clk_en`. It keeps the clock parked for `act_cycles` cycles, counted from the edge where the enable actually falls. From idle with `phase_low` held at 1, the enable returns `pwr_cycles + act_cycles` cycles after the request edge.
- R4: With `method_sel` = 1 (DLL pin pulse), the reset action holds `dll_off_n` at 0 for `act_cycles` cycles while the clock runs, and then raises it.
- R5: `ready` rises exactly `lock_cycles` cycles after both `mem_clk_en` and `dll_off_n` are 1 at the end of the reset action.
- R6: `ready` is 0 in the cycle that follows the edge sampling any request.
- R7: A request while `ready` is 1 reruns the reset action and lock wait without a power hold. With `phase_low` at 1, `ready` returns `act_cycles + lock_cycles` cycles after the request edge.
- R8: A request during an active sequence restarts it at the reset action, with the counts reloaded and timed from the latest request.
- R9: The counts and `method_sel` are captured on the request edge. Later changes to them have no effect on the running sequence.
- R10: A count of 0 behaves as a count of 1.
- R11: `mem_clk_en` changes only on a clock edge at which `phase_low` is 1. In clock-park mode, the parked time lies within `act_cycles` to `act_cycles + 1` cycles when `phase_low` alternates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset, released synchronously |
| start_req | input | 1 | Start or frequency-change request, one cycle per request |
| method_sel | input | 1 | 0 = park the clock pair, 1 = pulse the DLL-disable pin |
| phase_low | input | 1 | 1 when the memory clock is in its low phase at the next edge |
| pwr_cycles | input | CNT_W | Power-hold length in cycles |
| act_cycles | input | CNT_W | Reset-action length in cycles |
| lock_cycles | input | CNT_W | Lock-wait length in cycles |
| mem_clk_en | output | 1 | Enable for the memory clock pair; 0 parks it low |
| dll_off_n | output | 1 | Active-low DLL-disable pin drive |
| ready | output | 1 | DLL reset and lock sequence complete |

## Verification
The bench builds the block with an 8-bit count width. Short counts then finish whole power-up and frequency-change sequences in tens of cycles, and a lock count at the 8-bit maximum of 255 stays affordable, which exercises the full-width counter without wrap. Holding `phase_low` at 1 makes every event land on an exact cycle. Toggling it every cycle exercises the low-phase gating of the clock enable and the one-cycle slack this adds to the parked time.

// File: rtl/dls_pkg.sv
package dls_pkg;

  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_PWR_HOLD  = 3'd1,
    ST_RESET_ACT = 3'd2,
    ST_LOCK_WAIT = 3'd3,
    ST_READY     = 3'd4
  } dls_state_e;

  typedef enum logic {
    M_CLK_STOP = 1'b0,
    M_DLL_OFF  = 1'b1
  } dls_method_e;

  // Count fields carried through the configuration capture stage
  localparam int unsigned DLS_NUM_CNT = 3;
  localparam int unsigned IDX_PWR     = 0;
  localparam int unsigned IDX_ACT     = 1;
  localparam int unsigned IDX_LOCK    = 2;

endpackage

// File: rtl/dls_cfg_latch.sv
// Captures the counts and method on a request; bypasses the new values in
// the capture cycle so the first phase loads without a one-cycle lag.
module dls_cfg_latch
  import dls_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 capture,
  input  dls_method_e                          method_in,
  input  logic [DLS_NUM_CNT-1:0][CNT_W-1:0]    cnt_in,
  output dls_method_e                          method_eff,
  output dls_method_e                          method_q,
  output logic [DLS_NUM_CNT-1:0][CNT_W-1:0]    cnt_eff
);

  dls_method_e method_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      method_r <= M_CLK_STOP;
    end else if (capture) begin
      method_r <= method_in;
    end
  end

  assign method_eff = capture ? method_in : method_r;
  assign method_q   = method_r;

  for (genvar g = 0; g < DLS_NUM_CNT; g++) begin : g_field
    logic [CNT_W-1:0] field_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        field_q <= '0;
      end else if (capture) begin
        field_q <= cnt_in[g];
      end
    end

    assign cnt_eff[g] = capture ? cnt_in[g] : field_q;
  end

endmodule

// File: rtl/dls_timer.sv
// Down counter for one sequence phase. It counts only while cnt_en is set;
// done fires on the last counted cycle. A load of 0 expires like a load of 1.
module dls_timer #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             cnt_en,
  output logic             done
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    done  = cnt_en && (cnt_q <= CNT_W'(1));
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = load_val;
    end else if (cnt_en && (cnt_q != '0)) begin
      cnt_d = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/dls_clk_park.sv
// Registers the memory clock enable; a new value is taken only on an edge
// where the memory clock sits in its low phase, so the pair parks cleanly.
module dls_clk_park (
  input  logic clk,
  input  logic rst_n,
  input  logic en_req,
  input  logic phase_low,
  output logic en
);

  logic en_q;
  logic en_d;

  always_comb begin
    en_d = phase_low ? en_req : en_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0;
    end else begin
      en_q <= en_d;
    end
  end

  assign en = en_q;

  a_r11_gate_on_low_phase: assert property (
    @(posedge clk) disable iff (!rst_n)
    !$stable(en_q) |-> $past(phase_low)
  ) else $error("R11: clock enable changed outside a low phase");

endmodule

// File: rtl/dls_fsm.sv
module dls_fsm
  import dls_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_req,
  input  dls_method_e      method_eff,
  input  dls_method_e      method_q,
  input  logic [CNT_W-1:0] pwr_eff,
  input  logic [CNT_W-1:0] act_eff,
  input  logic [CNT_W-1:0] lock_eff,
  input  logic             clk_en,
  input  logic             tmr_done,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output logic             tmr_cnt_en,
  output logic             clk_en_req,
  output logic             dll_off_n,
  output logic             ready
);

  dls_state_e state_q;
  dls_state_e state_d;
  logic       restart;
  logic       dll_off_n_q;
  logic       dll_off_n_d;
  logic       ready_q;
  logic       ready_d;

  assign restart = start_req && (state_q != ST_IDLE);

  // Next state
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:      if (start_req) state_d = ST_PWR_HOLD;
      ST_PWR_HOLD:  if (restart || tmr_done) state_d = ST_RESET_ACT;
      ST_RESET_ACT: begin
        if (restart)       state_d = ST_RESET_ACT;
        else if (tmr_done) state_d = ST_LOCK_WAIT;
      end
      ST_LOCK_WAIT: begin
        if (restart)       state_d = ST_RESET_ACT;
        else if (tmr_done) state_d = ST_READY;
      end
      ST_READY:     if (restart) state_d = ST_RESET_ACT;
      default:      state_d = ST_IDLE;
    endcase
  end

  // Timer control: reload on every phase entry and on a restart
  always_comb begin
    tmr_load = restart || (state_d != state_q);
    unique case (state_d)
      ST_PWR_HOLD:  tmr_val = pwr_eff;
      ST_RESET_ACT: tmr_val = act_eff;
      ST_LOCK_WAIT: tmr_val = lock_eff;
      default:      tmr_val = '0;
    endcase
  end

  // A phase counts only while its effect is really present at the pins
  always_comb begin
    unique case (state_q)
      ST_PWR_HOLD:  tmr_cnt_en = 1'b1;
      ST_RESET_ACT: tmr_cnt_en = (method_q == M_CLK_STOP) ? !clk_en : !dll_off_n_q;
      ST_LOCK_WAIT: tmr_cnt_en = clk_en && dll_off_n_q;
      default:      tmr_cnt_en = 1'b0;
    endcase
  end

  // Output decode from the next state
  always_comb begin
    unique case (state_d)
      ST_RESET_ACT: begin
        dll_off_n_d = (method_eff == M_CLK_STOP);
        clk_en_req  = (method_eff == M_DLL_OFF);
      end
      ST_LOCK_WAIT, ST_READY: begin
        dll_off_n_d = 1'b1;
        clk_en_req  = 1'b1;
      end
      default: begin
        dll_off_n_d = 1'b0;
        clk_en_req  = 1'b0;
      end
    endcase
    ready_d = (state_d == ST_READY);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      dll_off_n_q <= 1'b0;
      ready_q     <= 1'b0;
    end else begin
      state_q     <= state_d;
      dll_off_n_q <= dll_off_n_d;
      ready_q     <= ready_d;
    end
  end

  assign dll_off_n = dll_off_n_q;
  assign ready     = ready_q;

  a_r2_hold_levels: assert property (
    @(posedge clk) disable iff (!rst_n)
    (state_q == ST_PWR_HOLD) |-> (!clk_en && !dll_off_n_q)
  ) else $error("R2: outputs not held low in power hold");

  a_r4_pin_low_in_action: assert property (
    @(posedge clk) disable iff (!rst_n)
    (state_q == ST_RESET_ACT && method_q == M_DLL_OFF) |-> !dll_off_n_q
  ) else $error("R4: DLL pin high during pulse action");

  a_r5_ready_needs_clock: assert property (
    @(posedge clk) disable iff (!rst_n)
    ready_q |-> (clk_en && dll_off_n_q)
  ) else $error("R5: ready without running clock and enabled DLL");

  a_r6_ready_drop: assert property (
    @(posedge clk) disable iff (!rst_n)
    start_req |=> !ready_q
  ) else $error("R6: ready still high after request");

  a_r8_restart_to_action: assert property (
    @(posedge clk) disable iff (!rst_n)
    (start_req && state_q != ST_IDLE) |=> (state_q == ST_RESET_ACT)
  ) else $error("R8: request did not restart at the reset action");

endmodule

// File: rtl/dll_lock_seq.sv
module dll_lock_seq
  import dls_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_req,
  input  logic             method_sel,
  input  logic             phase_low,
  input  logic [CNT_W-1:0] pwr_cycles,
  input  logic [CNT_W-1:0] act_cycles,
  input  logic [CNT_W-1:0] lock_cycles,
  output logic             mem_clk_en,
  output logic             dll_off_n,
  output logic             ready
);

  logic [DLS_NUM_CNT-1:0][CNT_W-1:0] cnt_in;
  logic [DLS_NUM_CNT-1:0][CNT_W-1:0] cnt_eff;
  dls_method_e method_eff;
  dls_method_e method_q;
  logic        tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic        tmr_cnt_en;
  logic        tmr_done;
  logic        clk_en_req;
  logic        clk_en;

  assign cnt_in[IDX_PWR]  = pwr_cycles;
  assign cnt_in[IDX_ACT]  = act_cycles;
  assign cnt_in[IDX_LOCK] = lock_cycles;

  dls_cfg_latch #(.CNT_W(CNT_W)) i_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .capture    (start_req),
    .method_in  (dls_method_e'(method_sel)),
    .cnt_in     (cnt_in),
    .method_eff (method_eff),
    .method_q   (method_q),
    .cnt_eff    (cnt_eff)
  );

  dls_fsm #(.CNT_W(CNT_W)) i_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_req  (start_req),
    .method_eff (method_eff),
    .method_q   (method_q),
    .pwr_eff    (cnt_eff[IDX_PWR]),
    .act_eff    (cnt_eff[IDX_ACT]),
    .lock_eff   (cnt_eff[IDX_LOCK]),
    .clk_en     (clk_en),
    .tmr_done   (tmr_done),
    .tmr_load   (tmr_load),
    .tmr_val    (tmr_val),
    .tmr_cnt_en (tmr_cnt_en),
    .clk_en_req (clk_en_req),
    .dll_off_n  (dll_off_n),
    .ready      (ready)
  );

  dls_timer #(.CNT_W(CNT_W)) i_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .cnt_en   (tmr_cnt_en),
    .done     (tmr_done)
  );

  dls_clk_park i_park (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_req    (clk_en_req),
    .phase_low (phase_low),
    .en        (clk_en)
  );

  assign mem_clk_en = clk_en;

endmodule

// File: tb/test_dll_lock_seq.sv
module test_dll_lock_seq;

  localparam int CW = 8;
  localparam int K_DOFF = 0;
  localparam int K_CLK  = 1;
  localparam int K_RDY  = 2;

  typedef struct {
    int    kind;
    int    exp;
    string req;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_req = 1'b0;
  logic          method_sel = 1'b0;
  logic          phase_low = 1'b1;
  logic [CW-1:0] pwr_cycles = '0;
  logic [CW-1:0] act_cycles = '0;
  logic [CW-1:0] lock_cycles = '0;
  logic          mem_clk_en;
  logic          dll_off_n;
  logic          ready;

  always #4 clk = ~clk;

  dll_lock_seq #(.CNT_W(CW)) i_dll_lock_seq (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .method_sel(method_sel),
    .phase_low(phase_low), .pwr_cycles(pwr_cycles), .act_cycles(act_cycles),
    .lock_cycles(lock_cycles), .mem_clk_en(mem_clk_en), .dll_off_n(dll_off_n),
    .ready(ready)
  );

  exp_t sbq[$];
  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int start_cyc = 0;
  int clk_rise_cyc = 0;
  int clk_fall_cyc = 0;
  int rdy_rise_cyc = 0;
  logic prev_en = 1'b0, prev_doff = 1'b0, prev_rdy = 1'b0, prev_phase = 1'b1;
  logic toggle_phase = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk) begin
    #2;
    if (toggle_phase) phase_low = ~phase_low;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic sb_pop(input int kind, input int val);
    exp_t it;
    if (sbq.size() == 0) begin
      check("R7 unexpected event", kind, -1);
    end else begin
      it = sbq.pop_front();
      check({it.req, " event kind"}, kind, it.kind);
      if (it.exp >= 0) check(it.req, val, it.exp);
    end
  endtask

  // Monitor: scoreboard consumer, runs between clock edges
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_clk_en != prev_en) check("R11 enable moved off low phase", int'(prev_phase), 1);
      if (!mem_clk_en && prev_en) clk_fall_cyc = cyc;
      if (dll_off_n && !prev_doff) sb_pop(K_DOFF, cyc - start_cyc);
      if (mem_clk_en && !prev_en) begin
        clk_rise_cyc = cyc;
        sb_pop(K_CLK, cyc - start_cyc);
      end
      if (ready && !prev_rdy) begin
        rdy_rise_cyc = cyc;
        sb_pop(K_RDY, cyc - start_cyc);
      end
    end
    prev_en    = mem_clk_en;
    prev_doff  = dll_off_n;
    prev_rdy   = ready;
    prev_phase = phase_low;
  end

  function automatic int eff(input int n);
    return (n == 0) ? 1 : n;
  endfunction

  task automatic push(input int kind, input int exp, input string req);
    exp_t it;
    it.kind = kind; it.exp = exp; it.req = req;
    sbq.push_back(it);
  endtask

  task automatic pulse();
    @(posedge clk); #2 start_req = 1'b1;
    @(posedge clk); #2 start_req = 1'b0;
    start_cyc = cyc;
  endtask

  // Driver: pushes expected events, then issues the request
  task automatic run_seq(input logic m, input int p, input int s, input int l,
                         input logic from_idle, input string req);
    int ps;
    ps = from_idle ? eff(p) : 0;
    method_sel = m; pwr_cycles = CW'(p); act_cycles = CW'(s); lock_cycles = CW'(l);
    if (!m) begin
      if (from_idle) push(K_DOFF, ps, "R2 pin rise after hold");
      push(K_CLK, ps + eff(s), {req, " clock restart"});
    end else begin
      if (from_idle) push(K_CLK, ps, "R2 clock start after hold");
      push(K_DOFF, ps + eff(s), {req, " pin rise"});
    end
    push(K_RDY, ps + eff(s) + eff(l), {req, " ready"});
    pulse();
    if (!from_idle) check("R6 ready low after request", int'(ready), 0);
  endtask

  task automatic wait_ready(input string req);
    int n = 0;
    while (!ready && n < 3000) begin
      @(negedge clk); n++;
    end
    @(negedge clk);
    check({req, " ready reached"}, int'(ready), 1);
  endtask

  initial begin
    // R1: reset state
    #3;
    check("R1 en in reset", int'(mem_clk_en), 0);
    check("R1 pin in reset", int'(dll_off_n), 0);
    check("R1 ready in reset", int'(ready), 0);
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (5) @(posedge clk);
    #2;
    check("R1 idle en", int'(mem_clk_en), 0);
    check("R1 idle pin", int'(dll_off_n), 0);
    check("R1 idle ready", int'(ready), 0);

    // Power-up, clock park
    run_seq(1'b0, 4, 6, 9, 1'b1, "R3");
    @(negedge clk);
    check("R2 en low in hold", int'(mem_clk_en), 0);
    check("R2 pin low in hold", int'(dll_off_n), 0);
    wait_ready("R3");

    // Frequency change, pin pulse
    run_seq(1'b1, 0, 5, 7, 1'b0, "R4");
    wait_ready("R4");

    // Frequency change, clock park
    run_seq(1'b0, 0, 3, 4, 1'b0, "R7");
    wait_ready("R7");

    // Restart during an active sequence
    run_seq(1'b0, 0, 6, 4, 1'b0, "R8");
    repeat (2) @(posedge clk);
    pulse();
    check("R8 ready low after restart", int'(ready), 0);
    wait_ready("R8");

    // Configuration changes after capture are ignored
    run_seq(1'b1, 0, 4, 6, 1'b0, "R9");
    method_sel = 1'b0; act_cycles = CW'(1); lock_cycles = CW'(1);
    wait_ready("R9");

    // Zero counts act as one
    run_seq(1'b0, 0, 0, 0, 1'b0, "R10");
    wait_ready("R10");

    // Alternating clock phase
    toggle_phase = 1'b1;
    method_sel = 1'b0; act_cycles = CW'(5); lock_cycles = CW'(7);
    push(K_CLK, -1, "R11 clock restart");
    push(K_RDY, -1, "R11 ready");
    pulse();
    wait_ready("R11");
    check("R11 parked time in window",
          int'((clk_rise_cyc - clk_fall_cyc) >= 5 && (clk_rise_cyc - clk_fall_cyc) <= 6), 1);
    check("R5 lock after clock restart", rdy_rise_cyc - clk_rise_cyc, 7);
    run_seq(1'b1, 0, 3, 3, 1'b0, "R4 phase toggling");
    wait_ready("R4 phase toggling");
    toggle_phase = 1'b0;
    @(posedge clk); #2 phase_low = 1'b1;

    // Reset mid-operation, then power-up with pin pulse and full lock count
    @(negedge clk); #1 rst_n = 1'b0;
    #1;
    check("R1 async en", int'(mem_clk_en), 0);
    check("R1 async pin", int'(dll_off_n), 0);
    check("R1 async ready", int'(ready), 0);
    @(posedge clk); #2 rst_n = 1'b1;
    run_seq(1'b1, 2, 3, 255, 1'b1, "R5");
    wait_ready("R5");

    check("R7 scoreboard drained", sbq.size(), 0);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule